// File: doc/BRIEF.md
# TLB Fault Context Capture

This block sits beside the exception logic of a processor core. When the memory-management unit reports a translation fault, the block records what the miss handler needs to rebuild the missing mapping. It stores the faulting virtual address and rewrites the address-space and page-number fields of the entry-high register and the bad-page field of the context register. It also hands the matching exception code to the vector logic. All three registers are held inside the block and read through output ports.

Software loads the remaining fields of the entry-high and context registers through a narrow write port. Examples are the page-table base, a spare field and the low context bits. A fault capture rewrites only the fields it owns and leaves every other field as it was.

The fault kind input uses this encoding: 0 = refill, 1 = invalid, 2 = modified, 3 = no fault. The entry-high register is laid out as follows, from the top bit down: VPN2 (VPN_W-2 bits), then VPN2X (2 bits), then a software field (EHI_SW_W bits), then ASID (ASID_W bits at the bottom). The context register is laid out as follows, from the top bit down: page-table base (PTE_W bits), then BadVPN2 (VPN_W-2 bits), then a low field (CTX_LOW_W bits).

Top module: `tlb_fault_capture`

## Requirements
- R1: Asynchronous active-low reset clears badVAddr, entryHi, ctxReg and excCode to zero, and drives codeValid low.
- R2: When faultStb is high with a kind of 0, 1 or 2, badVAddr holds faultVaddr after that clock edge.
- R3: On such an accepted fault, entryHi[ASID_W-1:0] takes faultAsid at the same edge.
- R4: On an accepted fault, the top VPN_W-2 bits of entryHi take faultVpn shifted right by two. The two bits just below them take faultVpn[1:0].
- R5: On an accepted fault, ctxReg[CTX_LOW_W +: VPN_W-2] takes faultVpn shifted right by two.
- R6: A fault capture leaves the entry-high software field, the context page-table base and the context low field unchanged.
- R7: Refill (0) and invalid (1) faults report excCode 3 when isStore is high and 2 when it is low.
- R8: A modified fault (2) reports excCode 1 whatever the value of isStore.
- R9: codeValid is high for exactly the one cycle after each accepted fault. excCode holds its last value otherwise.
- R10: With faultStb low, or with kind 3, no register changes and codeValid stays low, unless a software write is present.
- R11: When swWrEn is high and no fault is accepted, the register picked by swWrSel (0 = entryHi, 1 = ctxReg) is loaded whole from swWrData at that edge.
- R12: A software write in the same cycle as an accepted fault is dropped. Both registers show only the capture result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| faultStb | input | 1 | Fault report strobe |
| faultKind | input | 2 | 0 refill, 1 invalid, 2 modified, 3 none |
| isStore | input | 1 | Faulting access was a store |
| faultAsid | input | ASID_W | Address-space id of the faulting access |
| faultVaddr | input | VADDR_W | Faulting virtual address |
| faultVpn | input | VPN_W | Faulting virtual page number |
| swWrEn | input | 1 | Software write enable |
| swWrSel | input | 1 | Write target: 0 entryHi, 1 ctxReg |
| swWrData | input | max(EHI_W,CTX_W) | Software write data |
| badVAddr | output | VADDR_W | Captured faulting address |
| entryHi | output | EHI_W | Entry-high register |
| ctxReg | output | CTX_W | Context register |
| excCode | output | 5 | Exception code for the vector logic |
| codeValid | output | 1 | excCode refreshed by the previous edge |

## Verification
The bench builds the block with its default widths: a 32-bit address, an 8-bit ASID, a 20-bit page number, and 31-bit entry-high and context registers. With these widths every field sits in its own bit range, so a stray write into a neighbouring field shows up as a mismatch. The bench preloads all-ones and alternating patterns into the software-owned fields before the faults are applied. This makes any capture that disturbs a field it does not own visible at once. Back-to-back faults, collisions between a write and a fault, and no-fault kinds alongside writes bring the priority and pulse-width corners within reach.

// File: rtl/tlbcap_pkg.sv
package tlbcap_pkg;

  typedef enum logic [1:0] {
    FK_REFILL   = 2'd0,
    FK_INVALID  = 2'd1,
    FK_MODIFIED = 2'd2,
    FK_NONE     = 2'd3
  } faultKind_e;

  localparam int CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_MOD   = 5'd1;
  localparam logic [CODE_W-1:0] CODE_LOAD  = 5'd2;
  localparam logic [CODE_W-1:0] CODE_STORE = 5'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic              wrEhi;
    logic              wrCtx;
    logic [CODE_W-1:0] code;
  } capCtl_t;

endpackage

// File: rtl/tlbcap_ctrl.sv
module tlbcap_ctrl
  import tlbcap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultStb,
  input  logic [1:0] faultKind,
  input  logic       isStore,
  input  logic       swWrEn,
  input  logic       swWrSel,
  output capCtl_t    ctl
);

  logic accepted;

  always_comb begin
    accepted = faultStb && (faultKind != FK_NONE);
    ctl.capture = accepted;
    ctl.wrEhi = swWrEn && !accepted && !swWrSel;
    ctl.wrCtx = swWrEn && !accepted && swWrSel;
    case (faultKind)
      FK_MODIFIED: ctl.code = CODE_MOD;
      FK_REFILL,
      FK_INVALID:  ctl.code = isStore ? CODE_STORE : CODE_LOAD;
      default:     ctl.code = '0;
    endcase
  end

  // R8: modified faults always report code 1
  p_mod_code_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultStb && faultKind == FK_MODIFIED) |-> (ctl.capture && ctl.code == CODE_MOD));

  // R7: refill/invalid store vs load codes
  p_tlb_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultStb && (faultKind == FK_REFILL || faultKind == FK_INVALID))
      |-> (ctl.code == (isStore ? CODE_STORE : CODE_LOAD)));

  // R12: a capture always wins over a software write
  p_sw_lose_r12: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |-> !(ctl.wrEhi || ctl.wrCtx));

  // R11: the write strobes never both fire
  p_one_wr_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.wrEhi, ctl.wrCtx}));

endmodule

// File: rtl/tlbcap_dp.sv
module tlbcap_dp
  import tlbcap_pkg::*;
#(
  parameter int VADDR_W   = 32,
  parameter int ASID_W    = 8,
  parameter int VPN_W     = 20,
  parameter int EHI_SW_W  = 3,
  parameter int PTE_W     = 9,
  parameter int CTX_LOW_W = 4,
  parameter int EHI_W     = VPN_W + EHI_SW_W + ASID_W,
  parameter int CTX_W     = PTE_W + VPN_W - 2 + CTX_LOW_W,
  parameter int WR_W      = (EHI_W > CTX_W) ? EHI_W : CTX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  capCtl_t            ctl,
  input  logic [ASID_W-1:0]  faultAsid,
  input  logic [VADDR_W-1:0] faultVaddr,
  input  logic [VPN_W-1:0]   faultVpn,
  input  logic [WR_W-1:0]    swWrData,
  output logic [VADDR_W-1:0] badVAddr,
  output logic [EHI_W-1:0]   entryHi,
  output logic [CTX_W-1:0]   ctxReg,
  output logic [CODE_W-1:0]  excCode,
  output logic               codeValid
);

  localparam int VPN2_W  = VPN_W - 2;
  localparam int EHI_X_LO = ASID_W + EHI_SW_W;
  localparam int EHI_V_LO = EHI_X_LO + 2;
  localparam int CTX_V_LO = CTX_LOW_W;

  logic [VADDR_W-1:0] badVaQ;
  logic [EHI_W-1:0]   ehiQ, ehiNext;
  logic [CTX_W-1:0]   ctxQ, ctxNext;
  logic [CODE_W-1:0]  codeQ;
  logic               validQ;

  always_comb begin
    ehiNext = ehiQ;
    ctxNext = ctxQ;
    if (ctl.capture) begin
      ehiNext[ASID_W-1:0]        = faultAsid;
      ehiNext[EHI_X_LO +: 2]     = faultVpn[1:0];
      ehiNext[EHI_V_LO +: VPN2_W] = faultVpn[VPN_W-1:2];
      ctxNext[CTX_V_LO +: VPN2_W] = faultVpn[VPN_W-1:2];
    end else begin
      if (ctl.wrEhi) ehiNext = swWrData[EHI_W-1:0];
      if (ctl.wrCtx) ctxNext = swWrData[CTX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      badVaQ <= '0;
      ehiQ   <= '0;
      ctxQ   <= '0;
      codeQ  <= '0;
      validQ <= 1'b0;
    end else begin
      ehiQ   <= ehiNext;
      ctxQ   <= ctxNext;
      validQ <= ctl.capture;
      if (ctl.capture) begin
        badVaQ <= faultVaddr;
        codeQ  <= ctl.code;
      end
    end
  end

  assign badVAddr  = badVaQ;
  assign entryHi   = ehiQ;
  assign ctxReg    = ctxQ;
  assign excCode   = codeQ;
  assign codeValid = validQ;

  p_badva_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> badVAddr == $past(faultVaddr));

  p_asid_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> entryHi[ASID_W-1:0] == $past(faultAsid));

  p_vpn_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> (entryHi[EHI_V_LO +: VPN2_W] == $past(faultVpn[VPN_W-1:2]))
                 && (entryHi[EHI_X_LO +: 2] == $past(faultVpn[1:0])));

  p_ctx_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> ctxReg[CTX_V_LO +: VPN2_W] == $past(faultVpn[VPN_W-1:2]));

  p_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> $stable(entryHi[ASID_W +: EHI_SW_W])
                 && $stable(ctxReg[CTX_W-1 -: PTE_W])
                 && $stable(ctxReg[CTX_LOW_W-1:0]));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> codeValid && excCode == $past(ctl.code));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.capture || ctl.wrEhi || ctl.wrCtx)
      |=> $stable(entryHi) && $stable(ctxReg) && $stable(badVAddr) && !codeValid);

endmodule

// File: rtl/tlb_fault_capture.sv
module tlb_fault_capture
  import tlbcap_pkg::*;
#(
  parameter int VADDR_W   = 32,
  parameter int ASID_W    = 8,
  parameter int VPN_W     = 20,
  parameter int EHI_SW_W  = 3,
  parameter int PTE_W     = 9,
  parameter int CTX_LOW_W = 4,
  localparam int EHI_W    = VPN_W + EHI_SW_W + ASID_W,
  localparam int CTX_W    = PTE_W + VPN_W - 2 + CTX_LOW_W,
  localparam int WR_W     = (EHI_W > CTX_W) ? EHI_W : CTX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               faultStb,
  input  logic [1:0]         faultKind,
  input  logic               isStore,
  input  logic [ASID_W-1:0]  faultAsid,
  input  logic [VADDR_W-1:0] faultVaddr,
  input  logic [VPN_W-1:0]   faultVpn,
  input  logic               swWrEn,
  input  logic               swWrSel,
  input  logic [WR_W-1:0]    swWrData,
  output logic [VADDR_W-1:0] badVAddr,
  output logic [EHI_W-1:0]   entryHi,
  output logic [CTX_W-1:0]   ctxReg,
  output logic [4:0]         excCode,
  output logic               codeValid
);

  capCtl_t ctl;

  tlbcap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .faultStb (faultStb),
    .faultKind(faultKind),
    .isStore  (isStore),
    .swWrEn   (swWrEn),
    .swWrSel  (swWrSel),
    .ctl      (ctl)
  );

  tlbcap_dp #(
    .VADDR_W  (VADDR_W),
    .ASID_W   (ASID_W),
    .VPN_W    (VPN_W),
    .EHI_SW_W (EHI_SW_W),
    .PTE_W    (PTE_W),
    .CTX_LOW_W(CTX_LOW_W),
    .EHI_W    (EHI_W),
    .CTX_W    (CTX_W),
    .WR_W     (WR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .faultAsid (faultAsid),
    .faultVaddr(faultVaddr),
    .faultVpn  (faultVpn),
    .swWrData  (swWrData),
    .badVAddr  (badVAddr),
    .entryHi   (entryHi),
    .ctxReg    (ctxReg),
    .excCode   (excCode),
    .codeValid (codeValid)
  );

endmodule

// File: tb/tlb_fault_capture_tb.sv
module tlb_fault_capture_tb;

  localparam int VADDR_W = 32;
  localparam int ASID_W  = 8;
  localparam int VPN_W   = 20;
  localparam int SW_W    = 3;
  localparam int PTE_W   = 9;
  localparam int LOW_W   = 4;
  localparam int EHI_W   = VPN_W + SW_W + ASID_W;
  localparam int CTX_W   = PTE_W + VPN_W - 2 + LOW_W;
  localparam int WR_W    = (EHI_W > CTX_W) ? EHI_W : CTX_W;
  localparam int V2_W    = VPN_W - 2;
  localparam int X_LO    = ASID_W + SW_W;
  localparam int V_LO    = X_LO + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultStb = 1'b0;
  logic [1:0] faultKind = 2'd3;
  logic isStore = 1'b0;
  logic [ASID_W-1:0] faultAsid = '0;
  logic [VADDR_W-1:0] faultVaddr = '0;
  logic [VPN_W-1:0] faultVpn = '0;
  logic swWrEn = 1'b0;
  logic swWrSel = 1'b0;
  logic [WR_W-1:0] swWrData = '0;
  logic [VADDR_W-1:0] badVAddr;
  logic [EHI_W-1:0] entryHi;
  logic [CTX_W-1:0] ctxReg;
  logic [4:0] excCode;
  logic codeValid;

  always #5 clk = ~clk;

  tlb_fault_capture u_dut (
    .clk(clk), .rstN(rstN), .faultStb(faultStb), .faultKind(faultKind),
    .isStore(isStore), .faultAsid(faultAsid), .faultVaddr(faultVaddr),
    .faultVpn(faultVpn), .swWrEn(swWrEn), .swWrSel(swWrSel),
    .swWrData(swWrData), .badVAddr(badVAddr), .entryHi(entryHi),
    .ctxReg(ctxReg), .excCode(excCode), .codeValid(codeValid)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string scen = "R1";

  // behavioural reference model
  logic [VADDR_W-1:0] mBad;
  logic [EHI_W-1:0] mEhi;
  logic [CTX_W-1:0] mCtx;
  logic [4:0] mCode;
  logic mValid;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBad = '0; mEhi = '0; mCtx = '0; mCode = '0; mValid = 1'b0;
    end else begin
      mValid = faultStb && faultKind != 2'd3;
      if (mValid) begin
        mBad = faultVaddr;
        mEhi[ASID_W-1:0] = faultAsid;
        mEhi[V_LO +: V2_W] = faultVpn >> 2;
        mEhi[X_LO +: 2] = faultVpn & 20'h3;
        mCtx[LOW_W +: V2_W] = faultVpn >> 2;
        if (faultKind == 2'd2) mCode = 5'd1;
        else mCode = isStore ? 5'd3 : 5'd2;
      end else if (swWrEn) begin
        if (swWrSel) mCtx = swWrData[CTX_W-1:0];
        else mEhi = swWrData[EHI_W-1:0];
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] at %0t: actual=%h expected=%h", what, scen, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 badVAddr", 64'(badVAddr), 64'(mBad));
    chk("R3 asid", 64'(entryHi[ASID_W-1:0]), 64'(mEhi[ASID_W-1:0]));
    chk("R4 vpn2", 64'(entryHi[V_LO +: V2_W]), 64'(mEhi[V_LO +: V2_W]));
    chk("R4 vpn2x", 64'(entryHi[X_LO +: 2]), 64'(mEhi[X_LO +: 2]));
    chk("R6 ehi sw field", 64'(entryHi[ASID_W +: SW_W]), 64'(mEhi[ASID_W +: SW_W]));
    chk("R5 ctx badvpn2", 64'(ctxReg[LOW_W +: V2_W]), 64'(mCtx[LOW_W +: V2_W]));
    chk("R6 ctx pte base", 64'(ctxReg[CTX_W-1 -: PTE_W]), 64'(mCtx[CTX_W-1 -: PTE_W]));
    chk("R6 ctx low", 64'(ctxReg[LOW_W-1:0]), 64'(mCtx[LOW_W-1:0]));
    chk("R7 R8 excCode", 64'(excCode), 64'(mCode));
    chk("R9 codeValid", 64'(codeValid), 64'(mValid));
  endtask

  task automatic step(input logic stb, input logic [1:0] kind, input logic st,
                      input logic [ASID_W-1:0] asid, input logic [VADDR_W-1:0] va,
                      input logic [VPN_W-1:0] vpn, input logic we, input logic sel,
                      input logic [WR_W-1:0] wd);
    @(negedge clk);
    compareAll();
    faultStb = stb; faultKind = kind; isStore = st; faultAsid = asid;
    faultVaddr = va; faultVpn = vpn; swWrEn = we; swWrSel = sel; swWrData = wd;
  endtask

  task automatic idle();
    step(1'b0, 2'd3, 1'b0, '0, '0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 badVAddr", 64'(badVAddr), 64'd0);
    chk("R1 entryHi", 64'(entryHi), 64'd0);
    chk("R1 ctxReg", 64'(ctxReg), 64'd0);
    chk("R1 excCode", 64'(excCode), 64'd0);
    chk("R1 codeValid", 64'(codeValid), 64'd0);
    rstN = 1'b1;
    idle();

    // R11: software loads of both registers
    scen = "R11";
    step(1'b0, 2'd3, 1'b0, '0, '0, '0, 1'b1, 1'b0, 31'h7fff_ffff);
    step(1'b0, 2'd3, 1'b0, '0, '0, '0, 1'b1, 1'b1, 31'h2aaa_aaab);
    idle();

    // R7: refill/invalid, load and store
    scen = "R7";
    step(1'b1, 2'd0, 1'b0, 8'h12, 32'h1234_5678, 20'h12345, 1'b0, 1'b0, '0);
    step(1'b1, 2'd0, 1'b1, 8'hff, 32'hdead_beef, 20'hfffff, 1'b0, 1'b0, '0);
    step(1'b1, 2'd1, 1'b0, 8'h00, 32'h0000_0001, 20'h00001, 1'b0, 1'b0, '0);
    step(1'b1, 2'd1, 1'b1, 8'ha5, 32'h8000_0000, 20'h80002, 1'b0, 1'b0, '0);
    idle();

    // R8: modified with both store flags
    scen = "R8";
    step(1'b1, 2'd2, 1'b0, 8'h3c, 32'hcafe_f00d, 20'h5a5a6, 1'b0, 1'b0, '0);
    idle();
    step(1'b1, 2'd2, 1'b1, 8'hc3, 32'h0bad_cafe, 20'ha5a5b, 1'b0, 1'b0, '0);
    idle();
    idle();

    // R10: strobe low with data moving, and kind 3 with strobe high
    scen = "R10";
    step(1'b0, 2'd0, 1'b1, 8'h77, 32'h7777_7777, 20'h77777, 1'b0, 1'b0, '0);
    step(1'b1, 2'd3, 1'b1, 8'h66, 32'h6666_6666, 20'h66666, 1'b0, 1'b0, '0);
    idle();

    // R12: write collides with accepted fault
    scen = "R12";
    step(1'b0, 2'd3, 1'b0, '0, '0, '0, 1'b1, 1'b0, 31'h1555_5555);
    step(1'b1, 2'd0, 1'b1, 8'h9e, 32'h1357_9bdf, 20'h2468a, 1'b1, 1'b0, 31'h0000_0000);
    step(1'b1, 2'd1, 1'b0, 8'h01, 32'h2468_ace0, 20'h13579, 1'b1, 1'b1, 31'h7fff_ffff);
    // write proceeds alongside a non-fault kind
    step(1'b1, 2'd3, 1'b0, 8'h44, 32'h4444_4444, 20'h44444, 1'b1, 1'b1, 31'h5555_0000);
    idle();

    // R9: back-to-back faults then gap
    scen = "R9";
    for (int i = 0; i < 4; i++)
      step(1'b1, 2'(i % 3), 1'(i & 1), 8'(i * 37), 32'(i * 32'h0101_0101), 20'(i * 20'h11111), 1'b0, 1'b0, '0);
    idle();
    idle();

    // mixed random traffic
    scen = "R2 R3 R4 R5 R6 random";
    for (int i = 0; i < 400; i++)
      step(1'($urandom), 2'($urandom), 1'($urandom), 8'($urandom), 32'($urandom),
           20'($urandom), 1'(($urandom % 4) == 0), 1'($urandom), 31'($urandom));
    idle();
    idle();
    @(negedge clk);
    compareAll();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule